// File: doc/BRIEF.md
# Pulse Input Glitch Filter

This block cleans up an external pulse input before a pulse counter sees it. The input is resynchronised on a prescaler clock enable. It is then qualified by a stability counter, so the filtered level changes only after the input has held a new level for 2^N prescaler ticks. N is chosen by a 4-bit field and ranges from 2 to 16. A bypass mode skips the qualification, and every synchronised assertion goes straight through.

The block drives two outputs. One is the filtered level. The other is an increment strobe that rises once for each rising edge of that level, and a downstream counter uses it as its count enable. While the block is disabled, its view of the input is held at the asserted level. An input that is already high when the block is switched on therefore never counts.

Top module: `pulse_glitch_filter`

## Requirements
- R1: While `rstN` is low or `enable` is low, `filtLevel` reads 1 and `incStrobe` reads 0, and toggling `pulseIn` has no effect on either output.
- R2: Internal state and both outputs change only on clock edges where `tickEn` is 1, except for the forcing described in R1.
- R3: With filtering on, a rising `pulseIn` held steadily raises `filtLevel` exactly 2^N+2 tick edges after the first tick that samples it high: 2 edges of synchroniser delay plus 2^N edges of stability counting.
- R4: `filtLen` values 1 to 15 select N = filtLen+1, giving filter lengths from 2^2 to 2^16. The value 0 acts like the value 1, giving 2^2.
- R5: With filtering on, a high or low level that lasts fewer than 2^N ticks is not passed on. A level of exactly 2^N ticks is passed on.
- R6: With `bypass` at 1, `filtLevel` follows the synchronised input, and every input high level of at least one tick produces one strobe.
- R7: `incStrobe` goes high once per rising edge of `filtLevel` and stays high for exactly one tick period. When `tickEn` is held at 1, that is one clock cycle.
- R8: If `pulseIn` is already high when `enable` rises, no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Prescaler clock enable, one cycle per prescaler edge |
| enable | input | 1 | Block enable; low forces the input to its asserted state |
| bypass | input | 1 | 1 skips stability qualification |
| filtLen | input | 4 | Filter length code (N = filtLen+1, 0 treated as 1) |
| pulseIn | input | 1 | Selected, polarity-corrected pulse input |
| filtLevel | output | 1 | Qualified input level |
| incStrobe | output | 1 | Counter increment strobe, one tick period wide |

## Verification
The assertions check the following on every cycle:
- the stability counter never passes its limit;
- nothing moves between ticks;
- the disabled state forces both outputs;
- a strobe never survives a second tick;
- two filtered level changes are always at least 2^N ticks apart.

Some behaviour only the bench scenarios can show. These are the exact 2^N+2 edge latency, the choice between rejecting and accepting at the 2^N boundary, the effect of the length code 0, and the rule that an input already high at enable does not count. They need known stimulus and a known expected count of strobes.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
  // Strobes passed from control to datapath.
  typedef struct packed {
    logic tick;    // advance state this cycle
    logic clear;   // block disabled: force asserted input, clear counting
    logic bypass;  // pass synchronised input straight through
  } pgfCtrl_t;
endpackage

// File: rtl/pgf_ctrl.sv
module pgf_ctrl
  import pgf_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 4
) (
  input  logic             enable,
  input  logic             tickEn,
  input  logic             bypass,
  input  logic [LEN_W-1:0] filtLen,
  output pgfCtrl_t         ctrl,
  output logic [CNT_W-1:0] limit
);
  localparam int EXP_W = LEN_W + 1;
  localparam logic [EXP_W-1:0] MIN_EXP = EXP_W'(2);

  logic [EXP_W-1:0] lenExp;

  // Code 0 acts like code 1; otherwise exponent is code + 1.
  always_comb begin
    if (filtLen == '0) lenExp = MIN_EXP;
    else               lenExp = EXP_W'(filtLen) + EXP_W'(1);
  end

  // limit = 2^N - 1 as a low-order mask of N ones.
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign limit[i] = (EXP_W'(i) < lenExp);
  end

  always_comb begin
    ctrl.tick   = tickEn & enable;
    ctrl.clear  = ~enable;
    ctrl.bypass = bypass;
  end

  // R4
  always_comb begin
    min_length_chk: assert (limit[1:0] == 2'b11);
  end
endmodule

// File: rtl/pgf_sync.sv
module pgf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic clear,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage;

  // Stages preset to the asserted level on reset or while disabled.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      stage[s] <= 1'b1;
      else if (clear) stage[s] <= 1'b1;
      else if (tick)  stage[s] <= (s == 0) ? din : stage[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/pgf_datapath.sv
module pgf_datapath
  import pgf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pgfCtrl_t         ctrl,
  input  logic [CNT_W-1:0] limit,
  input  logic             syncIn,
  output logic             filtLevel,
  output logic             incStrobe
);
  localparam int GAP_W = CNT_W + 1;

  logic [CNT_W-1:0] stabCnt, stabCntNext;
  logic             levelNext;
  logic             differ, reached;

  assign differ  = (syncIn != filtLevel);
  assign reached = (stabCnt == limit);

  always_comb begin
    if (ctrl.bypass) begin
      levelNext   = syncIn;
      stabCntNext = '0;
    end else if (differ && reached) begin
      levelNext   = ~filtLevel;
      stabCntNext = '0;
    end else if (differ) begin
      levelNext   = filtLevel;
      stabCntNext = stabCnt + CNT_W'(1);
    end else begin
      levelNext   = filtLevel;
      stabCntNext = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtLevel <= 1'b1;
      stabCnt   <= '0;
      incStrobe <= 1'b0;
    end else if (ctrl.clear) begin
      filtLevel <= 1'b1;
      stabCnt   <= '0;
      incStrobe <= 1'b0;
    end else if (ctrl.tick) begin
      filtLevel <= levelNext;
      stabCnt   <= stabCntNext;
      incStrobe <= levelNext & ~filtLevel;
    end
  end

  // Monitor: ticks since the last level change, saturating.
  logic [GAP_W-1:0] gapCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       gapCnt <= '0;
    else if (ctrl.clear)             gapCnt <= '0;
    else if (ctrl.tick) begin
      if (levelNext != filtLevel)    gapCnt <= '0;
      else if (gapCnt != '1)         gapCnt <= gapCnt + GAP_W'(1);
    end
  end

  // R5
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.clear |-> (stabCnt <= limit));

  // R1
  disabled_forced_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clear |=> (filtLevel && !incStrobe));

  // R2
  hold_off_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.tick && !ctrl.clear) |=> ($stable(filtLevel) && $stable(incStrobe)));

  // R7
  strobe_one_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (incStrobe && ctrl.tick && !ctrl.clear) |=> !incStrobe);

  // R7
  strobe_with_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(incStrobe) |-> filtLevel);

  // R3
  change_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.clear && !$past(ctrl.clear) && !ctrl.bypass && !$past(ctrl.bypass)
     && (filtLevel != $past(filtLevel)))
    |-> ($past(gapCnt) >= {1'b0, limit}));
endmodule

// File: rtl/pulse_glitch_filter.sv
module pulse_glitch_filter
  import pgf_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LEN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             enable,
  input  logic             bypass,
  input  logic [LEN_W-1:0] filtLen,
  input  logic             pulseIn,
  output logic             filtLevel,
  output logic             incStrobe
);
  pgfCtrl_t         ctrl;
  logic [CNT_W-1:0] limit;
  logic             syncIn;

  pgf_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctrl (
    .enable  (enable),
    .tickEn  (tickEn),
    .bypass  (bypass),
    .filtLen (filtLen),
    .ctrl    (ctrl),
    .limit   (limit)
  );

  pgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rstN  (rstN),
    .tick  (ctrl.tick),
    .clear (ctrl.clear),
    .din   (pulseIn),
    .dout  (syncIn)
  );

  pgf_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .limit     (limit),
    .syncIn    (syncIn),
    .filtLevel (filtLevel),
    .incStrobe (incStrobe)
  );
endmodule

// File: tb/pulse_glitch_filter_test.sv
module pulse_glitch_filter_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic       enable = 1'b0;
  logic       bypass = 1'b0;
  logic [3:0] filtLen = 4'd1;
  logic       pulseIn = 1'b0;
  logic       filtLevel, incStrobe;

  int errors = 0;
  int checks = 0;
  int tickPeriod = 1;
  int divCnt = 0;
  int rises = 0;
  int highCycles = 0;
  logic prevStrobe = 1'b0;
  int cycles = 0;

  always #5 clk = ~clk;

  pulse_glitch_filter uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .enable(enable), .bypass(bypass),
    .filtLen(filtLen), .pulseIn(pulseIn), .filtLevel(filtLevel), .incStrobe(incStrobe)
  );

  // Prescaler enable, one cycle in tickPeriod.
  always @(negedge clk) begin
    divCnt = (divCnt + 1 >= tickPeriod) ? 0 : divCnt + 1;
    tickEn = (divCnt == 0);
  end

  // Strobe monitor.
  always @(negedge clk) begin
    if (incStrobe) highCycles++;
    if (incStrobe && !prevStrobe) rises++;
    prevStrobe = incStrobe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int lenOf(input logic [3:0] code);
    return (code == 4'd0) ? 4 : (1 << (code + 1));
  endfunction

  // Restart the block with a config and settle with the input low.
  task automatic restart(input logic byp, input logic [3:0] code);
    @(negedge clk);
    enable = 1'b0;
    bypass = byp;
    filtLen = code;
    pulseIn = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    waitCycles((lenOf(code) + 8) * tickPeriod);
  endtask

  // bypass | code | high ticks | low ticks | expected strobes
  localparam logic [31:0] VEC [10] = '{
    32'h0104_0403, 32'h0103_0800, 32'h0104_0301, 32'h0208_0803, 32'h0207_1400,
    32'h1101_0103, 32'h1502_0103, 32'h0004_0403, 32'h0003_0400, 32'h0310_1003
  };

  // Exact rise latency: 2^N+2 tick edges after the first sampling tick.
  task automatic latencyTest(input logic [3:0] code);
    int n;
    n = lenOf(code);
    restart(1'b0, code);
    check(filtLevel == 1'b0, "R3 settled low", filtLevel, 0);
    pulseIn = 1'b1;
    waitCycles(n + 1);
    check(filtLevel == 1'b0, "R3 not yet risen", filtLevel, 0);
    waitCycles(1);
    check(filtLevel == 1'b1, "R3 risen on time", filtLevel, 1);
    check(incStrobe == 1'b1, "R7 strobe with rise", incStrobe, 1);
    waitCycles(1);
    check(incStrobe == 1'b0, "R7 strobe one cycle", incStrobe, 0);
  endtask

  initial begin
    // Reset state (R1)
    waitCycles(3);
    check(filtLevel == 1'b1, "R1 reset level", filtLevel, 1);
    check(incStrobe == 1'b0, "R1 reset strobe", incStrobe, 0);
    rstN = 1'b1;
    waitCycles(2);
    // Disabled: input toggling ignored (R1)
    for (int i = 0; i < 6; i++) begin
      pulseIn = ~pulseIn;
      waitCycles(3);
      check(filtLevel == 1'b1 && incStrobe == 1'b0, "R1 disabled ignores input",
            {filtLevel, incStrobe}, 2);
    end

    // Table of pulse trains (R3, R4, R5, R6, R7)
    foreach (VEC[k]) begin
      logic [31:0] v;
      int baseR, baseH, hi, lo, ex;
      v = VEC[k];
      hi = int'(v[23:16]); lo = int'(v[15:8]); ex = int'(v[7:0]);
      restart(v[28], v[27:24]);
      baseR = rises; baseH = highCycles;
      for (int p = 0; p < 3; p++) begin
        pulseIn = 1'b1; waitCycles(hi);
        pulseIn = 1'b0; waitCycles(lo);
      end
      waitCycles(lenOf(v[27:24]) + 8);
      check(rises - baseR == ex, v[28] ? "R6 bypass strobes" : "R5 filtered strobes",
            rises - baseR, ex);
      check(highCycles - baseH == rises - baseR, "R7 strobe width",
            highCycles - baseH, rises - baseR);
    end

    // Input already high at enable (R8)
    @(negedge clk);
    enable = 1'b0; bypass = 1'b0; filtLen = 4'd1; pulseIn = 1'b1;
    waitCycles(2);
    begin
      int baseR;
      baseR = rises;
      enable = 1'b1;
      waitCycles(20);
      check(rises == baseR, "R8 high at enable no strobe", rises - baseR, 0);
      check(filtLevel == 1'b1, "R8 level stays high", filtLevel, 1);
    end

    // Exact latency at shortest length and with code 0 (R3, R4)
    latencyTest(4'd1);
    latencyTest(4'd0);

    // Divided prescaler: strobe spans one tick period (R2, R7)
    tickPeriod = 4;
    begin
      int baseR, baseH;
      restart(1'b0, 4'd1);
      baseR = rises; baseH = highCycles;
      pulseIn = 1'b1; waitCycles(6 * 4);
      pulseIn = 1'b0; waitCycles(12 * 4);
      check(rises - baseR == 1, "R2 divided tick strobe count", rises - baseR, 1);
      check(highCycles - baseH == 4, "R7 strobe spans tick period", highCycles - baseH, 4);
    end
    tickPeriod = 1;

    // Longest length (R4, R3)
    latencyTest(4'd15);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule